// File: doc/BRIEF.md
# Two-Element Load-and-Replicate Unit

This unit executes one SIMD load that fetches a pair of adjacent elements from memory and fills two 64-bit vector registers. Every lane of the first register receives a copy of the first element, and every lane of the second register receives a copy of the second element. An issue stage presents a 32-bit instruction word together with the current values of the base and index general registers. The unit decodes the word and checks it for illegal encodings and for a misaligned address. It then issues a single byte-addressed read on a valid/ready memory port and waits for the returned data.

When the data arrives, the unit writes both vector results in one cycle through a dual write port into a 32-entry by 64-bit vector register file. In the same cycle it can write an updated base address into a 16-entry by 32-bit general register file. A one-cycle completion pulse marks the end of every instruction. The pulse carries an undefined-instruction flag or an alignment-fault flag when the instruction was rejected, and in that case no register is written.

Top module: `dup2_load_unit`

## Requirements
- R1: Instruction bits [7:6] give the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. Value 3 ends the instruction with `undef` set on the `done` pulse, with no memory request and no register write.
- R2: Instruction bit 4 requests an alignment check. When it is 1 and the base is not a multiple of twice the element byte count, `align_fault` is set on the `done` pulse, no request is made and nothing is written. When the bit is 0, any base is accepted. `undef` takes priority and the two flags are never set together.
- R3: The first vector destination is {bit 22, bits [15:12]}. The second is the first plus 1 when bit 5 is 0, and the first plus 2 when bit 5 is 1. A second destination above 31 sets `undef` with no request and no write.
- R4: An accepted legal instruction makes exactly one memory request. The request address is the base value and its byte count is twice the element byte count. Address and count stay unchanged while the request waits for `mem_req_ready`.
- R5: The first element is taken little-endian from the lowest bytes of the returned data, and the second from the bytes just above it. Each element is copied into every lane of its 64-bit result: 8, 4 or 2 copies.
- R6: Bits [3:0] select the base update. With 15 there is no general-register write. With 13 the base grows by twice the element byte count. Any other value adds `rm_value`. The addition wraps at 32 bits, uses the base value taken at acceptance, and writes the register named by bits [19:16].
- R7: A base register field (bits [19:16]) of 15 sets `undef` with no request and no write.
- R8: `instr_ready` is high only while idle. An `instr_valid` seen while busy is ignored. `done` lasts one cycle, and the vector and general-register write enables are high only during that cycle.
- R9: After reset the unit is idle: `instr_ready` is high, and `done`, `mem_req_valid` and both write enables are low.
- R10: Instruction bits [31:23], [21:20] and [11:8] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction taken when valid |
| instr_word | input | 32 | Encoded instruction |
| rn_value | input | 32 | Current value of the base register |
| rm_value | input | 32 | Current value of the index register |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_req_bytes | output | 4 | Bytes requested (2, 4 or 8) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, byte 0 at the lowest bits |
| vr_we | output | 1 | Vector write enable (both ports) |
| vr_waddr0 | output | 5 | First vector destination |
| vr_wdata0 | output | 64 | First replicated result |
| vr_waddr1 | output | 5 | Second vector destination |
| vr_wdata1 | output | 64 | Second replicated result |
| gpr_we | output | 1 | Base register write enable |
| gpr_waddr | output | 4 | Base register index |
| gpr_wdata | output | 32 | Updated base address |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined instruction, valid with done |
| align_fault | output | 1 | Alignment fault, valid with done |

## Verification
The bench sweeps every combination of element width (all four codes), register spacing, alignment request, the three base-update modes and all eight byte offsets within a doubleword. It rotates the destination, base and index fields, so that destinations past 31 and a base field of 15 occur along the way. The offsets separate a correct alignment mask from one that is too wide or too narrow for each width. The per-byte memory pattern catches an element taken from the wrong byte lane or replicated with the wrong width. Bases near the top of the address space exercise 32-bit wrap of the update. Varying stalls and response latencies, together with junk instructions offered while busy, show whether the handshake ignores input at the wrong time.

// File: rtl/dup2_pkg.sv
package dup2_pkg;

    localparam int VEC_W  = 64;
    localparam int ADDR_W = 32;
    localparam int GPR_AW = 4;
    localparam int VR_AW  = 5;
    localparam int INSN_W = 32;
    localparam int NSIZES = 3;
    localparam int BYTE_W = 8;

    // Instruction field positions
    localparam int F_DHI   = 22;
    localparam int F_RN_LO = 16;
    localparam int F_VD_LO = 12;
    localparam int F_SZ_LO = 6;
    localparam int F_SPC   = 5;
    localparam int F_ALN   = 4;
    localparam int F_RM_LO = 0;

    localparam logic [GPR_AW-1:0] RM_NO_WB  = 4'd15;
    localparam logic [GPR_AW-1:0] RM_IMM_WB = 4'd13;
    localparam logic [GPR_AW-1:0] RN_BAD    = 4'd15;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_BAD = 2'd3
    } elem_sz_e;

    typedef enum logic [1:0] {
        WB_NONE = 2'd0,
        WB_IMM  = 2'd1,
        WB_REG  = 2'd2
    } wb_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_ABORT  = 3'd4
    } st_e;

    typedef struct packed {
        elem_sz_e          sz;
        logic [3:0]        ebytes;
        logic [VR_AW-1:0]  vd0;
        logic [VR_AW-1:0]  vd1;
        logic              align_req;
        wb_mode_e          wb;
        logic [GPR_AW-1:0] rn;
        logic              undef;
    } dec_t;

    // Byte count of the whole pair: twice the element size
    function automatic logic [3:0] pair_bytes(input logic [3:0] eb);
        return {eb[2:0], 1'b0};
    endfunction

endpackage

// File: rtl/dup2_decode.sv
module dup2_decode
    import dup2_pkg::*;
(
    input  logic [INSN_W-1:0] instr_word,
    output dec_t              dec
);

    logic [1:0]        raw_sz;
    logic [VR_AW-1:0]  first_d;
    logic [VR_AW:0]    second_wide;
    logic [GPR_AW-1:0] rm_f;
    logic [GPR_AW-1:0] rn_f;
    logic              unused_bits;

    assign raw_sz      = instr_word[F_SZ_LO +: 2];
    assign first_d     = {instr_word[F_DHI], instr_word[F_VD_LO +: VR_AW-1]};
    assign second_wide = {1'b0, first_d} + (instr_word[F_SPC] ? (VR_AW+1)'(2) : (VR_AW+1)'(1));
    assign rm_f        = instr_word[F_RM_LO +: GPR_AW];
    assign rn_f        = instr_word[F_RN_LO +: GPR_AW];
    assign unused_bits = ^{instr_word[31:23], instr_word[21:20], instr_word[11:8]};

    always_comb begin
        dec           = '0;
        dec.sz        = elem_sz_e'(raw_sz);
        dec.ebytes    = 4'd1 << raw_sz;
        dec.vd0       = first_d;
        dec.vd1       = second_wide[VR_AW-1:0];
        dec.align_req = instr_word[F_ALN];
        dec.rn        = rn_f;
        if (rm_f == RM_NO_WB)
            dec.wb = WB_NONE;
        else if (rm_f == RM_IMM_WB)
            dec.wb = WB_IMM;
        else
            dec.wb = WB_REG;
        dec.undef = (raw_sz == 2'd3) || (rn_f == RN_BAD) || second_wide[VR_AW];
    end

endmodule

// File: rtl/dup2_align_check.sv
module dup2_align_check
    import dup2_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  elem_sz_e          sz,
    input  logic              align_req,
    output logic              misalign
);

    logic [2:0]    low_mask;
    logic          unused_hi;

    // Pair of elements must sit on a 2*ebytes boundary
    always_comb begin
        case (sz)
            SZ_B:    low_mask = 3'b001;
            SZ_H:    low_mask = 3'b011;
            SZ_W:    low_mask = 3'b111;
            default: low_mask = 3'b000;
        endcase
    end

    assign misalign  = align_req && ((base[2:0] & low_mask) != 3'b000);
    assign unused_hi = ^base[ADDR_W-1:3];

endmodule

// File: rtl/dup2_lane_fill.sv
module dup2_lane_fill
    import dup2_pkg::*;
(
    input  logic [VEC_W-1:0] raw,
    input  elem_sz_e         sz,
    output logic [VEC_W-1:0] lane_a,
    output logic [VEC_W-1:0] lane_b
);

    logic [VEC_W-1:0] rep_a [NSIZES];
    logic [VEC_W-1:0] rep_b [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int EW   = BYTE_W << s;
        localparam int NCPY = VEC_W / EW;
        for (genvar c = 0; c < NCPY; c++) begin : g_copy
            assign rep_a[s][c*EW +: EW] = raw[0  +: EW];
            assign rep_b[s][c*EW +: EW] = raw[EW +: EW];
        end
    end

    always_comb begin
        case (sz)
            SZ_B: begin lane_a = rep_a[0]; lane_b = rep_b[0]; end
            SZ_H: begin lane_a = rep_a[1]; lane_b = rep_b[1]; end
            SZ_W: begin lane_a = rep_a[2]; lane_b = rep_b[2]; end
            default: begin lane_a = '0; lane_b = '0; end
        endcase
    end

endmodule

// File: rtl/dup2_load_unit.sv
module dup2_load_unit
    import dup2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [31:0]       instr_word,
    input  logic [31:0]       rn_value,
    input  logic [31:0]       rm_value,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    output logic [3:0]        mem_req_bytes,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              vr_we,
    output logic [4:0]        vr_waddr0,
    output logic [63:0]       vr_wdata0,
    output logic [4:0]        vr_waddr1,
    output logic [63:0]       vr_wdata1,
    output logic              gpr_we,
    output logic [3:0]        gpr_waddr,
    output logic [31:0]       gpr_wdata,
    output logic              done,
    output logic              undef,
    output logic              align_fault
);

    st_e               st_q;
    dec_t              dec_now;
    dec_t              dec_q;
    logic              misalign_now;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] idx_q;
    logic [VEC_W-1:0]  data_q;
    logic              undef_q;
    logic              af_q;
    logic [ADDR_W-1:0] step;

    dup2_decode u_decode (
        .instr_word (instr_word),
        .dec        (dec_now)
    );

    dup2_align_check u_align (
        .base      (rn_value),
        .sz        (dec_now.sz),
        .align_req (dec_now.align_req),
        .misalign  (misalign_now)
    );

    dup2_lane_fill u_fill (
        .raw    (data_q),
        .sz     (dec_q.sz),
        .lane_a (vr_wdata0),
        .lane_b (vr_wdata1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            dec_q   <= '0;
            base_q  <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            undef_q <= 1'b0;
            af_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (instr_valid) begin
                        dec_q  <= dec_now;
                        base_q <= rn_value;
                        idx_q  <= rm_value;
                        if (dec_now.undef) begin
                            undef_q <= 1'b1;
                            st_q    <= ST_ABORT;
                        end else if (misalign_now) begin
                            af_q <= 1'b1;
                            st_q <= ST_ABORT;
                        end else begin
                            st_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        data_q <= mem_rsp_data;
                        st_q   <= ST_COMMIT;
                    end
                end
                ST_COMMIT: st_q <= ST_IDLE;
                ST_ABORT: begin
                    undef_q <= 1'b0;
                    af_q    <= 1'b0;
                    st_q    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign step = (dec_q.wb == WB_IMM) ? ADDR_W'(pair_bytes(dec_q.ebytes)) : idx_q;

    assign instr_ready   = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_REQ);
    assign mem_req_addr  = base_q;
    assign mem_req_bytes = pair_bytes(dec_q.ebytes);
    assign vr_we         = (st_q == ST_COMMIT);
    assign vr_waddr0     = dec_q.vd0;
    assign vr_waddr1     = dec_q.vd1;
    assign gpr_we        = (st_q == ST_COMMIT) && (dec_q.wb != WB_NONE);
    assign gpr_waddr     = dec_q.rn;
    assign gpr_wdata     = base_q + step;
    assign done          = (st_q == ST_COMMIT) || (st_q == ST_ABORT);
    assign undef         = (st_q == ST_ABORT) && undef_q;
    assign align_fault   = (st_q == ST_ABORT) && af_q;

endmodule

// File: rtl/dup2_load_unit_chk.sv
module dup2_load_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic [3:0]  mem_req_bytes,
    input logic        vr_we,
    input logic [4:0]  vr_waddr0,
    input logic [63:0] vr_wdata0,
    input logic [4:0]  vr_waddr1,
    input logic [63:0] vr_wdata1,
    input logic        gpr_we,
    input logic        done,
    input logic        undef,
    input logic        align_fault
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    write_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        (vr_we || gpr_we) |-> done);

    // R8
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !instr_ready);

    // R1
    fault_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (undef || align_fault) |-> (!vr_we && !gpr_we));

    // R2
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        align_fault |-> !undef);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes)));

    // R4
    req_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> $countones(mem_req_bytes) == 1 && !mem_req_bytes[0]);

    // R3
    spacing_chk: assert property (@(posedge clk) disable iff (rst)
        vr_we |-> (({1'b0, vr_waddr1} == {1'b0, vr_waddr0} + 6'd1) ||
                   ({1'b0, vr_waddr1} == {1'b0, vr_waddr0} + 6'd2)));

    // R5
    replicate_chk: assert property (@(posedge clk) disable iff (rst)
        vr_we |-> (vr_wdata0[63:32] == vr_wdata0[31:0]) &&
                  (vr_wdata1[63:32] == vr_wdata1[31:0]));

endmodule

bind dup2_load_unit dup2_load_unit_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_ready   (instr_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_bytes (mem_req_bytes),
    .vr_we         (vr_we),
    .vr_waddr0     (vr_waddr0),
    .vr_wdata0     (vr_wdata0),
    .vr_waddr1     (vr_waddr1),
    .vr_wdata1     (vr_wdata1),
    .gpr_we        (gpr_we),
    .done          (done),
    .undef         (undef),
    .align_fault   (align_fault)
);

// File: tb/dup2_load_unit_tb.sv
`timescale 1ns/1ps
module dup2_load_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [31:0] instr_word = '0;
    logic [31:0] rn_value = '0;
    logic [31:0] rm_value = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [3:0]  mem_req_bytes;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        vr_we;
    logic [4:0]  vr_waddr0;
    logic [63:0] vr_wdata0;
    logic [4:0]  vr_waddr1;
    logic [63:0] vr_wdata1;
    logic        gpr_we;
    logic [3:0]  gpr_waddr;
    logic [31:0] gpr_wdata;
    logic        done;
    logic        undef;
    logic        align_fault;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    dup2_load_unit u_dut (
        .clk (clk), .rst (rst),
        .instr_valid (instr_valid), .instr_ready (instr_ready),
        .instr_word (instr_word), .rn_value (rn_value), .rm_value (rm_value),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_req_bytes (mem_req_bytes),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .vr_we (vr_we), .vr_waddr0 (vr_waddr0), .vr_wdata0 (vr_wdata0),
        .vr_waddr1 (vr_waddr1), .vr_wdata1 (vr_wdata1),
        .gpr_we (gpr_we), .gpr_waddr (gpr_waddr), .gpr_wdata (gpr_wdata),
        .done (done), .undef (undef), .align_fault (align_fault)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [63:0] exp_lane(input logic [31:0] start, input int eb);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = mem_byte(start + 32'(b % eb));
        return r;
    endfunction

    task automatic run_one(input int idx, input logic [31:0] word,
                           input logic [31:0] base, input logic [31:0] rmv);
        int          sz, eb, d0, d2, rn, rm, nreq, stall, rsp_cnt;
        bit          t, al, ex_undef, ex_af, ex_fault, got_done, junk;
        logic [31:0] req_addr, ex_wb;
        logic [3:0]  req_bytes;
        string       ulab;
        sz  = int'(word[7:6]);
        eb  = 1 << sz;
        t   = word[5];
        al  = word[4];
        rm  = int'(word[3:0]);
        rn  = int'(word[19:16]);
        d0  = int'({word[22], word[15:12]});
        d2  = d0 + (t ? 2 : 1);
        ex_undef = (sz == 3) || (rn == 15) || (d2 > 31);
        ex_af    = !ex_undef && al && ((base % (2*eb)) != 0);
        ex_fault = ex_undef || ex_af;
        ulab = (sz == 3) ? "R1" : ((rn == 15) ? "R7" : ((d2 > 31) ? "R3" : "R1"));
        ex_wb = (rm == 13) ? base + 32'(2*eb) : base + rmv;
        junk  = (idx % 4) == 3;
        stall = idx % 2;
        rsp_cnt = -1;
        nreq = 0;
        got_done = 0;
        req_addr = '0;
        req_bytes = '0;

        @(negedge clk);
        chk("R8", "ready before issue", {63'd0, instr_ready}, 64'd1);
        instr_valid = 1'b1;
        instr_word  = word;
        rn_value    = base;
        rm_value    = rmv;
        for (int cyc = 0; cyc < 40 && !got_done; cyc++) begin
            @(negedge clk);
            if (junk) begin
                instr_valid = 1'b1;
                instr_word  = 32'h0000_00C0;
                rn_value    = ~base;
                rm_value    = ~rmv;
            end else begin
                instr_valid = 1'b0;
            end
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (done) begin
                got_done = 1;
                instr_valid = 1'b0;
                chk(ulab, "undef flag", {63'd0, undef}, {63'd0, ex_undef});
                chk("R2", "align_fault flag", {63'd0, align_fault}, {63'd0, ex_af});
                chk("R4", "request count", 64'(nreq), ex_fault ? 64'd0 : 64'd1);
                if (ex_fault) begin
                    chk(ulab, "no vector write", {63'd0, vr_we}, 64'd0);
                    chk(ulab, "no base write", {63'd0, gpr_we}, 64'd0);
                end else begin
                    chk("R4", "request addr", {32'd0, req_addr}, {32'd0, base});
                    chk("R4", "request bytes", {60'd0, req_bytes}, 64'(2*eb));
                    chk("R8", "vector write in done", {63'd0, vr_we}, 64'd1);
                    chk("R3", "first dest", 64'(vr_waddr0), 64'(d0));
                    chk("R3", "second dest", 64'(vr_waddr1), 64'(d2));
                    chk("R5", "first lane fill", vr_wdata0, exp_lane(base, eb));
                    chk("R5", "second lane fill", vr_wdata1, exp_lane(base + 32'(eb), eb));
                    chk("R6", "base write enable", {63'd0, gpr_we}, (rm == 15) ? 64'd0 : 64'd1);
                    if (rm != 15) begin
                        chk("R6", "base index", 64'(gpr_waddr), 64'(rn));
                        chk("R6", "updated base", {32'd0, gpr_wdata}, {32'd0, ex_wb});
                    end
                end
            end else begin
                if (vr_we || gpr_we)
                    chk("R8", "write outside done", {62'd0, vr_we, gpr_we}, 64'd0);
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    for (int b = 0; b < 8; b++)
                        mem_rsp_data[b*8 +: 8] = mem_byte(req_addr + 32'(b));
                    rsp_cnt = -1;
                end else if (rsp_cnt > 0) begin
                    rsp_cnt--;
                end
                if (mem_req_valid) begin
                    if (stall > 0) begin
                        stall--;
                        req_addr = mem_req_addr;
                    end else begin
                        if (nreq > 0 || mem_req_addr != req_addr && req_addr != 0)
                            chk("R4", "request held stable", {32'd0, mem_req_addr}, {32'd0, req_addr});
                        mem_req_ready = 1'b1;
                        nreq++;
                        req_addr  = mem_req_addr;
                        req_bytes = mem_req_bytes;
                        rsp_cnt   = idx % 3;
                    end
                end
            end
        end
        if (!got_done) chk("R8", "done seen", 64'd0, 64'd1);
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        chk("R8", "done one cycle", {63'd0, done}, 64'd0);
        chk("R8", "idle after done", {63'd0, instr_ready}, 64'd1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int idx;
        logic [31:0] w, base, rmv;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "ready in reset", {63'd0, instr_ready}, 64'd1);
        chk("R9", "done in reset", {63'd0, done}, 64'd0);
        chk("R9", "request in reset", {63'd0, mem_req_valid}, 64'd0);
        chk("R9", "writes in reset", {62'd0, vr_we, gpr_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9", "ready after reset", {63'd0, instr_ready}, 64'd1);
        idx = 0;
        for (int sz = 0; sz < 4; sz++)
            for (int t = 0; t < 2; t++)
                for (int al = 0; al < 2; al++)
                    for (int mi = 0; mi < 3; mi++)
                        for (int off = 0; off < 8; off++) begin
                            // R10: unused fields carry varying junk
                            w = {9'(idx * 37), 1'b0, 2'(idx), 20'd0};
                            w[22]    = 1'((idx / 7) % 2);
                            w[19:16] = 4'((idx * 5) % 16);
                            w[15:12] = 4'((idx * 3) % 16);
                            w[11:8]  = 4'(idx * 11);
                            w[7:6]   = 2'(sz);
                            w[5]     = 1'(t);
                            w[4]     = 1'(al);
                            w[3:0]   = (mi == 0) ? 4'd15 : ((mi == 1) ? 4'd13 : 4'(idx % 12));
                            base = (idx % 5 == 4) ? 32'hFFFF_FFF8 + 32'(off)
                                                  : 32'h0000_4000 + 32'(idx * 64) + 32'(off);
                            rmv  = 32'hF000_0000 + 32'(idx * 256);
                            run_one(idx, w, base, rmv);
                            idx++;
                        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule